// File: doc/BRIEF.md
# Floating-Point Register Bank with Width-Dependent Pairing

This block holds the 32 floating-point general registers of a processor and checks the format of every access against a format tag kept for each entry. A wide-mode input picks one of two layouts. When wide mode is set, every entry holds a full 64-bit value. When it is clear, only the low 32 bits of an entry count, and a 64-bit value lives in an even/odd pair: the odd (higher-numbered) register holds the upper half and the even register holds the lower half.

Every access names a register and a format. When a read's format does not match the tag stored for that register, the tag becomes unknown and the read returns the quiet NaN pattern for the requested format. If the register has never been given a format, the read assigns the requested format as its tag. Some accesses cannot be carried out in the narrow layout: a 64-bit format on an odd register, or any paired-single access. These raise a reserved-instruction exception pulse in the same cycle.

The block has no flow control. Each port has a plain enable and is always accepted, so there is no back-pressure. The read port is combinational, and any tag change it causes is committed at the next rising clock edge. The write port commits its data and tags at the rising clock edge.

Top module: `fpr_bank`

## Requirements
- R1: Format codes on rd_fmt and wr_fmt are: 0 raw-64 (uninterpreted), 1 single, 2 word, 3 double, 4 long, 5 paired-single, 6 unknown, 7 raw-32 (write only; stored tag becomes raw-64, and a raw-32 read acts like raw-64). After reset (rst_n low) every tag is raw-64 and every entry is zero, so a raw-64 read in wide mode returns 0.
- R2: In wide mode, a write of raw-64, double, long or paired-single stores all 64 bits and sets the tag. A read in the same format then returns the value. rsv_exc never asserts in wide mode.
- R3: A single, word or raw-32 write stores the low 32 bits of wr_data and zeroes the upper 32. A single or word read returns only the low 32 bits of the entry, zero-extended.
- R4: In narrow mode, a raw-64, double or long access to even register N uses entry N+1 for bits 63:32 and entry N for bits 31:0. A write stores each half zero-extended in its entry and tags both entries.
- R5: In narrow mode, a raw-64, double or long access to an odd register asserts rsv_exc. A read then returns 0. A write marks the tags of N and N+1 (when N+1 exists) unknown.
- R6: In narrow mode, any paired-single access asserts rsv_exc. A read then returns 0, and a write marks the target tag unknown.
- R7: A read whose effective format differs from the stored tag makes the tag unknown. An unknown-tagged read returns 0x7FBFFFFF (single), 0x7FFFFFFF (word), 0x7FF7FFFFFFFFFFFF (double), 0x7FFFFFFFFFFFFFFF (long) or 0x7FBFFFFF7FBFFFFF (paired-single), already in the read that caused the mismatch.
- R8: A read of a raw-64-tagged register adopts the requested format as its tag. A raw-64 request uses the stored tag as its format. A raw request on an unknown tag returns 0.
- R9: A read of an unknown-tagged register returns the quiet NaN without asserting rsv_exc, also in the cases where R5 or R6 would otherwise apply.
- R10: Writes take effect at the rising clock edge. When a read and a write touch the same tag in one cycle, the write's tag wins. A write in the unknown format marks the tag unknown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | 1: 64-bit entries, 0: 32-bit entries with pairing |
| rd_en | input | 1 | Read access valid this cycle |
| rd_idx | input | 5 | Read register index |
| rd_fmt | input | 3 | Read format code |
| rd_data | output | 64 | Read result (combinational) |
| wr_en | input | 1 | Write access valid this cycle |
| wr_idx | input | 5 | Write register index |
| wr_fmt | input | 3 | Write format code |
| wr_data | input | 64 | Write value |
| rsv_exc | output | 1 | Reserved-instruction exception for the current access |

## Verification
A corrupted tag shows up at the ports the first time the register is read in its proper format. In that case a stored value comes back as a quiet NaN, or the reverse happens. A wrong tag update is therefore visible one cycle after the access that caused it. Errors in pairing or half selection appear in the very next read of the even register in narrow mode, or in a wide-mode raw read of each half. A wrong exception decision appears in the same cycle as the access, because rsv_exc is combinational.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  localparam int DW = 64;
  localparam int HW = 32;

  typedef enum logic [2:0] {
    FMT_RAW64   = 3'd0,
    FMT_SINGLE  = 3'd1,
    FMT_WORD    = 3'd2,
    FMT_DOUBLE  = 3'd3,
    FMT_LONG    = 3'd4,
    FMT_PAIRED  = 3'd5,
    FMT_UNKNOWN = 3'd6,
    FMT_RAW32   = 3'd7
  } fmt_e;

  // canonical quiet NaN per requested format; zero when no pattern exists
  function automatic logic [DW-1:0] quiet_nan(input fmt_e f);
    case (f)
      FMT_SINGLE: quiet_nan = 64'h0000_0000_7FBF_FFFF;
      FMT_WORD:   quiet_nan = 64'h0000_0000_7FFF_FFFF;
      FMT_DOUBLE: quiet_nan = 64'h7FF7_FFFF_FFFF_FFFF;
      FMT_LONG:   quiet_nan = 64'h7FFF_FFFF_FFFF_FFFF;
      FMT_PAIRED: quiet_nan = 64'h7FBF_FFFF_7FBF_FFFF;
      default:    quiet_nan = '0;
    endcase
  endfunction

  function automatic logic is_half(input fmt_e f);
    is_half = (f == FMT_SINGLE) || (f == FMT_WORD) || (f == FMT_RAW32);
  endfunction

  function automatic logic is_full_scalar(input fmt_e f);
    is_full_scalar = (f == FMT_RAW64) || (f == FMT_DOUBLE) || (f == FMT_LONG);
  endfunction
endpackage

// File: rtl/fpr_rd_path.sv
module fpr_rd_path
  import fpr_pkg::*;
(
  input  logic          wide_mode,
  input  fmt_e          req_fmt,
  input  fmt_e          cur_tag,
  input  logic [DW-1:0] lo_entry,
  input  logic [HW-1:0] hi_word,
  input  logic          idx_odd,
  output logic [DW-1:0] data,
  output logic          exc,
  output fmt_e          new_tag,
  output logic          tag_chg
);
  fmt_e eff;
  fmt_e adopted;

  always_comb begin
    if (req_fmt == FMT_RAW64 || req_fmt == FMT_RAW32 || req_fmt == FMT_UNKNOWN)
      eff = cur_tag;
    else
      eff = req_fmt;
    adopted = (cur_tag == FMT_RAW64) ? eff : cur_tag;
    new_tag = (eff != adopted) ? FMT_UNKNOWN : adopted;
    tag_chg = (new_tag != cur_tag);
  end

  always_comb begin
    data = '0;
    exc  = 1'b0;
    if (new_tag == FMT_UNKNOWN) begin
      data = quiet_nan(eff);
    end else if (is_half(eff)) begin
      data = {{(DW-HW){1'b0}}, lo_entry[HW-1:0]};
    end else if (wide_mode) begin
      data = lo_entry;
    end else if (is_full_scalar(eff) && !idx_odd) begin
      data = {hi_word, lo_entry[HW-1:0]};
    end else begin
      exc = 1'b1;
    end
  end
endmodule

// File: rtl/fpr_wr_path.sv
module fpr_wr_path
  import fpr_pkg::*;
(
  input  logic          wide_mode,
  input  fmt_e          fmt,
  input  logic          idx_odd,
  input  logic [DW-1:0] data,
  output logic          lo_dwe,
  output logic [DW-1:0] lo_data,
  output logic          lo_twe,
  output fmt_e          lo_tag,
  output logic          hi_dwe,
  output logic [DW-1:0] hi_data,
  output logic          hi_twe,
  output fmt_e          hi_tag,
  output logic          exc
);
  always_comb begin
    lo_dwe  = 1'b0;
    lo_data = data;
    lo_twe  = 1'b0;
    lo_tag  = fmt;
    hi_dwe  = 1'b0;
    hi_data = {{(DW-HW){1'b0}}, data[DW-1:HW]};
    hi_twe  = 1'b0;
    hi_tag  = fmt;
    exc     = 1'b0;
    if (is_half(fmt)) begin
      lo_dwe  = 1'b1;
      lo_data = {{(DW-HW){1'b0}}, data[HW-1:0]};
      lo_twe  = 1'b1;
      lo_tag  = (fmt == FMT_RAW32) ? FMT_RAW64 : fmt;
    end else if (fmt == FMT_UNKNOWN) begin
      lo_twe = 1'b1;
      lo_tag = FMT_UNKNOWN;
    end else if (wide_mode) begin
      lo_dwe = 1'b1;
      lo_twe = 1'b1;
    end else if (is_full_scalar(fmt) && !idx_odd) begin
      lo_dwe  = 1'b1;
      lo_data = {{(DW-HW){1'b0}}, data[HW-1:0]};
      lo_twe  = 1'b1;
      hi_dwe  = 1'b1;
      hi_twe  = 1'b1;
    end else if (is_full_scalar(fmt)) begin
      lo_twe = 1'b1;
      lo_tag = FMT_UNKNOWN;
      hi_twe = 1'b1;
      hi_tag = FMT_UNKNOWN;
      exc    = 1'b1;
    end else begin
      lo_twe = 1'b1;
      lo_tag = FMT_UNKNOWN;
      exc    = 1'b1;
    end
  end
endmodule

// File: rtl/fpr_bank.sv
module fpr_bank
  import fpr_pkg::*;
#(
  parameter int NREG = 32,
  localparam int IW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wide_mode,
  input  logic          rd_en,
  input  logic [IW-1:0] rd_idx,
  input  logic [2:0]    rd_fmt,
  output logic [63:0]   rd_data,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [2:0]    wr_fmt,
  input  logic [63:0]   wr_data,
  output logic          rsv_exc
);
  logic [DW-1:0] ent_vec [NREG];
  fmt_e          tag_vec [NREG];

  logic [IW-1:0] rd_nxt, wr_nxt;
  logic          rd_last, wr_last;
  logic [HW-1:0] rd_hi_word;

  fmt_e          rd_new_tag;
  logic          rd_tag_chg, rd_exc;

  logic          w_lo_dwe, w_lo_twe, w_hi_dwe, w_hi_twe, wr_exc;
  logic [DW-1:0] w_lo_data, w_hi_data;
  fmt_e          w_lo_tag, w_hi_tag;

  assign rd_nxt     = rd_idx + IW'(1);
  assign wr_nxt     = wr_idx + IW'(1);
  assign rd_last    = (rd_idx == IW'(NREG-1));
  assign wr_last    = (wr_idx == IW'(NREG-1));
  assign rd_hi_word = rd_last ? '0 : ent_vec[rd_nxt][HW-1:0];

  fpr_rd_path u_rd (
    .wide_mode (wide_mode),
    .req_fmt   (fmt_e'(rd_fmt)),
    .cur_tag   (tag_vec[rd_idx]),
    .lo_entry  (ent_vec[rd_idx]),
    .hi_word   (rd_hi_word),
    .idx_odd   (rd_idx[0]),
    .data      (rd_data),
    .exc       (rd_exc),
    .new_tag   (rd_new_tag),
    .tag_chg   (rd_tag_chg)
  );

  fpr_wr_path u_wr (
    .wide_mode (wide_mode),
    .fmt       (fmt_e'(wr_fmt)),
    .idx_odd   (wr_idx[0]),
    .data      (wr_data),
    .lo_dwe    (w_lo_dwe),
    .lo_data   (w_lo_data),
    .lo_twe    (w_lo_twe),
    .lo_tag    (w_lo_tag),
    .hi_dwe    (w_hi_dwe),
    .hi_data   (w_hi_data),
    .hi_twe    (w_hi_twe),
    .hi_tag    (w_hi_tag),
    .exc       (wr_exc)
  );

  assign rsv_exc = (rd_en & rd_exc) | (wr_en & wr_exc);

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    logic [DW-1:0] ent_q;
    fmt_e          tag_q;
    logic          sel_lo_w, sel_hi_w, sel_rd;

    assign sel_lo_w = wr_en && (wr_idx == IW'(g));
    assign sel_hi_w = wr_en && !wr_last && (wr_nxt == IW'(g));
    assign sel_rd   = rd_en && rd_tag_chg && (rd_idx == IW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_q <= '0;
        tag_q <= FMT_RAW64;
      end else begin
        if (sel_lo_w && w_lo_dwe)      ent_q <= w_lo_data;
        else if (sel_hi_w && w_hi_dwe) ent_q <= w_hi_data;
        if (sel_lo_w && w_lo_twe)      tag_q <= w_lo_tag;
        else if (sel_hi_w && w_hi_twe) tag_q <= w_hi_tag;
        else if (sel_rd)               tag_q <= rd_new_tag;
      end
    end

    assign ent_vec[g] = ent_q;
    assign tag_vec[g] = tag_q;
  end
endmodule

// File: rtl/fpr_bank_chk.sv
module fpr_bank_chk #(
  parameter int IW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wide_mode,
  input logic          rd_en,
  input logic [IW-1:0] rd_idx,
  input logic [2:0]    rd_fmt,
  input logic [63:0]   rd_data,
  input logic          wr_en,
  input logic [IW-1:0] wr_idx,
  input logic [2:0]    wr_fmt,
  input logic [63:0]   wr_data,
  input logic          rsv_exc
);
  a_r2_no_exc_wide: assert property (@(posedge clk) disable iff (!rst_n)
    wide_mode |-> !rsv_exc);

  a_r3_half_read_zext: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (rd_fmt == 3'd1 || rd_fmt == 3'd2)) |-> (rd_data[63:32] == 32'h0));

  a_r2_write_read_back: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && $past(wide_mode) && $past(wr_fmt) == 3'd3 &&
     rd_en && wide_mode && rd_fmt == 3'd3 && rd_idx == $past(wr_idx))
    |-> (rd_data == $past(wr_data)));

  a_r5_odd_write_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wide_mode && wr_idx[0] &&
     (wr_fmt == 3'd0 || wr_fmt == 3'd3 || wr_fmt == 3'd4)) |-> rsv_exc);

  a_r6_paired_read_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wide_mode && rd_fmt == 3'd5 && rd_data != 64'h7FBF_FFFF_7FBF_FFFF)
    |-> rsv_exc);
endmodule

bind fpr_bank fpr_bank_chk #(.IW(IW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wide_mode (wide_mode),
  .rd_en     (rd_en),
  .rd_idx    (rd_idx),
  .rd_fmt    (rd_fmt),
  .rd_data   (rd_data),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .wr_fmt    (wr_fmt),
  .wr_data   (wr_data),
  .rsv_exc   (rsv_exc)
);

// File: tb/tb_fpr_bank.sv
module tb_fpr_bank;
  localparam logic [2:0] F_RAW = 3'd0, F_S = 3'd1, F_W = 3'd2, F_D = 3'd3,
                         F_L = 3'd4, F_PS = 3'd5, F_UNK = 3'd6, F_R32 = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_mode = 1'b1;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [4:0]  rd_idx = '0, wr_idx = '0;
  logic [2:0]  rd_fmt = '0, wr_fmt = '0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic        rsv_exc;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fpr_bank dut (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_fmt(rd_fmt), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_fmt(wr_fmt), .wr_data(wr_data),
    .rsv_exc(rsv_exc)
  );

  function automatic logic [63:0] qn(input logic [2:0] f);
    case (f)
      F_S:  return 64'h7FBFFFFF;
      F_W:  return 64'h7FFFFFFF;
      F_D:  return 64'h7FF7FFFFFFFFFFFF;
      F_L:  return 64'h7FFFFFFFFFFFFFFF;
      F_PS: return 64'h7FBFFFFF7FBFFFFF;
      default: return 64'h0;
    endcase
  endfunction

  function automatic logic [63:0] pat(input int i);
    return 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h0101_0011_0101_0011);
  endfunction

  function automatic logic [2:0] full_fmt(input int i);
    case (i % 3)
      0: return F_D;
      1: return F_L;
      default: return F_PS;
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input string req, input logic m,
                      input logic we, input int wi, input logic [2:0] wf, input logic [63:0] wd,
                      input logic re, input int ri, input logic [2:0] rf,
                      input logic cd, input logic [63:0] ed, input logic ex);
    @(negedge clk);
    wide_mode = m;
    wr_en = we; wr_idx = 5'(wi); wr_fmt = wf; wr_data = wd;
    rd_en = re; rd_idx = 5'(ri); rd_fmt = rf;
    #1;
    if (cd) chk(req, rd_data, ed);
    chk(req, 64'(rsv_exc), 64'(ex));
    @(posedge clk);
  endtask

  task automatic wr(input string req, input logic m, input int i, input logic [2:0] f,
                    input logic [63:0] d, input logic ex);
    step(req, m, 1'b1, i, f, d, 1'b0, 0, F_RAW, 1'b0, 64'h0, ex);
  endtask

  task automatic rd(input string req, input logic m, input int i, input logic [2:0] f,
                    input logic [63:0] ed, input logic ex);
    step(req, m, 1'b0, 0, F_RAW, 64'h0, 1'b1, i, f, 1'b1, ed, ex);
  endtask

  initial begin
    do_reset();
    // R1: reset state
    for (int i = 0; i < 32; i++) rd("R1 reset zero", 1'b1, i, F_RAW, 64'h0, 1'b0);

    // R2: wide-mode full writes and read-back
    for (int i = 0; i < 32; i++) begin
      wr("R2 wide write", 1'b1, i, full_fmt(i), pat(i), 1'b0);
      rd("R2 wide read", 1'b1, i, full_fmt(i), pat(i), 1'b0);
    end
    // R7: mismatched read gives NaN of request, then of stored format
    for (int i = 0; i < 32; i++) begin
      logic [2:0] other;
      other = (i % 2 == 0) ? F_S : ((full_fmt(i) == F_L) ? F_D : F_L);
      rd("R7 mismatch", 1'b1, i, other, qn(other), 1'b0);
      rd("R7 sticky unknown", 1'b1, i, full_fmt(i), qn(full_fmt(i)), 1'b0);
    end
    rd("R8 raw on unknown", 1'b1, 0, F_RAW, 64'h0, 1'b0);

    // R3: half writes zero the upper half
    do_reset();
    wr("R3 raw32 write", 1'b1, 5, F_R32, 64'hFFFF_FFFF_89AB_CDEF, 1'b0);
    rd("R3 raw32 zero upper", 1'b1, 5, F_RAW, 64'h0000_0000_89AB_CDEF, 1'b0);
    wr("R3 single write", 1'b1, 6, F_S, 64'hDEAD_BEEF_3F80_0000, 1'b0);
    rd("R3 single read", 1'b1, 6, F_S, 64'h3F80_0000, 1'b0);
    rd("R3 raw uses single tag", 1'b1, 6, F_RAW, 64'h3F80_0000, 1'b0);
    wr("R3 word write", 1'b1, 7, F_W, 64'h1111_2222_3333_4444, 1'b0);
    rd("R3 word read", 1'b1, 7, F_W, 64'h3333_4444, 1'b0);

    // R8: adoption of format on an uninterpreted tag
    wr("R8 raw write", 1'b1, 9, F_RAW, 64'hCAFE_F00D_1234_5678, 1'b0);
    rd("R8 adopt long", 1'b1, 9, F_L, 64'hCAFE_F00D_1234_5678, 1'b0);
    rd("R8 adopted tag mismatch", 1'b1, 9, F_D, qn(F_D), 1'b0);

    // R4: narrow-mode pairing
    do_reset();
    for (int e = 0; e < 32; e += 2) begin
      wr("R4 pair write", 1'b0, e, F_D, pat(e), 1'b0);
      rd("R4 pair read", 1'b0, e, F_D, pat(e), 1'b0);
      rd("R4 upper in odd", 1'b1, e + 1, F_RAW, {32'h0, pat(e) >> 32}, 1'b0);
      rd("R4 lower in even", 1'b1, e, F_RAW, {32'h0, pat(e) & 64'hFFFF_FFFF}, 1'b0);
    end
    do_reset();
    wr("R4 raw32 low", 1'b0, 2, F_R32, 64'h0000_0000_AAAA_0001, 1'b0);
    wr("R4 raw32 high", 1'b0, 3, F_R32, 64'h0000_0000_BBBB_0002, 1'b0);
    rd("R4 combine", 1'b0, 2, F_D, 64'hBBBB_0002_AAAA_0001, 1'b0);

    // R5 and R9: odd 64-bit access in narrow mode
    wr("R5 odd write exc", 1'b0, 5, F_D, 64'h1, 1'b1);
    rd("R5 R9 odd tag unknown", 1'b0, 5, F_S, qn(F_S), 1'b0);
    rd("R5 R9 neighbour unknown", 1'b0, 6, F_W, qn(F_W), 1'b0);
    wr("R5 last odd write exc", 1'b0, 31, F_L, 64'h2, 1'b1);
    rd("R5 R9 last unknown", 1'b0, 31, F_L, qn(F_L), 1'b0);
    rd("R5 odd read exc", 1'b0, 11, F_D, 64'h0, 1'b1);

    // R6 and R9: paired-single in narrow mode
    wr("R6 paired write exc", 1'b0, 10, F_PS, 64'h5, 1'b1);
    rd("R6 R9 paired unknown", 1'b0, 10, F_PS, qn(F_PS), 1'b0);
    rd("R6 paired read exc", 1'b0, 12, F_PS, 64'h0, 1'b1);
    rd("R2 R6 paired read wide", 1'b1, 12, F_PS, 64'h0, 1'b0);

    // R10: write wins over read tag change; unknown-format write
    do_reset();
    wr("R10 first write", 1'b1, 20, F_D, 64'h1111, 1'b0);
    step("R10 same cycle", 1'b1, 1'b1, 20, F_D, 64'h2222, 1'b1, 20, F_S, 1'b1, qn(F_S), 1'b0);
    rd("R10 write won", 1'b1, 20, F_D, 64'h2222, 1'b0);
    wr("R10 unknown write", 1'b1, 20, F_UNK, 64'h3333, 1'b0);
    rd("R10 unknown tag", 1'b1, 20, F_D, qn(F_D), 1'b0);

    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule